// File: doc/BRIEF.md
# Byte FIFO pair for a two-wire bus master

This block buffers bytes between a word-wide register port and the byte-serial engine of a two-wire bus master. It has two independent byte queues. Software fills the transmit queue one byte per register write, and the engine drains it. The engine fills the receive queue, and software drains it one byte per register read.

A control register holds a high and a low watermark and a self-clearing bit that empties both queues at once. A count register reports how full each queue is. Software can rewrite the high watermark in the middle of a transfer to match the bytes still expected, so that one event also covers a short final chunk. Four level flags go to an interrupt controller: transmit empty, transmit full, receive full, and receive at or above the high watermark. Edge capture and masking of these flags are done outside this block.

Register offsets on `addr_i`:
- 0: transmit data (write)
- 1: receive data (read)
- 2: queue control (read and write)
- 3: occupancy (read)

Top module: `i2c_mfifo`

## Requirements
- R1: After reset, both queues are empty. `tx_empty_o`=1, `tx_full_o`=0, `rx_full_o`=0 and `rx_hi_o`=0. The occupancy register reads 0, and the control register reads 0x0000_8000 (high watermark 128, low watermark 0).
- R2: A write to offset 0 pushes `wdata_i[7:0]` into the transmit queue, and bits 31:8 are dropped. `tx_data_o` shows the oldest byte. Each `tx_pop_i` cycle removes that byte, so bytes leave in the order they were written.
- R3: `rx_push_i` pushes `rx_data_i` into the receive queue. While `rd_i` is high at offset 1, `rdata_o[7:0]` holds the oldest received byte and bits 31:8 are zero. That byte is removed at the clock edge.
- R4: Each queue holds 128 bytes. A push to a full queue is ignored, even when a pop happens in the same cycle, and the queue contents are kept. `tx_full_o` and `rx_full_o` are high while the matching queue holds 128 bytes.
- R5: A pop from an empty queue is ignored. A read of offset 1 while the receive queue is empty returns zero.
- R6: The occupancy register (offset 3) returns the receive count in bits 7:0 and the transmit count in bits 15:8. All other bits are zero.
- R7: The control register (offset 2) stores the high watermark in bits 15:8 and the low watermark in bits 7:0 and reads them back. Bit 16 always reads 0.
- R8: A control write with bit 16 set empties both queues at that clock edge. The reset takes priority over any push or pop in the same cycle. The watermarks are written from the same word.
- R9: `rx_hi_o` is high exactly while the receive count is at or above the high watermark. A new watermark takes effect from the edge that writes it.
- R10: `tx_empty_o` is high exactly while the transmit count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register offset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational from addr_i) |
| tx_pop_i | input | 1 | Engine takes the transmit head byte |
| tx_data_o | output | 8 | Transmit head byte (zero when empty) |
| rx_push_i | input | 1 | Engine delivers a received byte |
| rx_data_i | input | 8 | Received byte |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_full_o | output | 1 | Transmit queue full |
| rx_full_o | output | 1 | Receive queue full |
| rx_hi_o | output | 1 | Receive count at or above the high watermark |

## Verification
A pointer or count that is out of step with the other shows up at the ports on the first pop after the fault. Either the wrong byte order appears on `tx_data_o` or `rdata_o`, or the occupancy register disagrees with the number of pushes minus pops. A lost wrap-around first becomes visible after the 128th push, which is why the bench fills each queue past capacity and then drains it completely. A watermark comparison that is off by one changes `rx_hi_o` one byte early or late. The bench therefore steps the receive count across the watermark one byte at a time and also rewrites the watermark above and below the current count.

// File: rtl/i2c_mfifo_pkg.sv
package i2c_mfifo_pkg;
  typedef enum logic [1:0] {
    REG_TXDATA = 2'd0,
    REG_RXDATA = 2'd1,
    REG_FCTRL  = 2'd2,
    REG_WCNT   = 2'd3
  } reg_sel_e;

  localparam int CLR_BIT = 16;
  localparam int HI_LSB  = 8;
  localparam int FLD_W   = 8;
endpackage

// File: rtl/i2c_mfifo_buf.sv
module i2c_mfifo_buf #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic [CW-1:0] cnt_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_o == '0);
  assign full_o  = (cnt_o == CW'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign dout_o  = empty_o ? '0 : mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_ok && !clr_i) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_o  <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_o  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_o <= cnt_o + 1'b1;
        2'b01:   cnt_o <= cnt_o - 1'b1;
        default: cnt_o <= cnt_o;
      endcase
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CW'(DEPTH));
  // R4
  full_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !clr_i) |=> (full_o && $stable(wr_ptr)));
  // R5
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i && !clr_i) |=> (empty_o && $stable(rd_ptr)));
endmodule

// File: rtl/i2c_mfifo_ctrl.sv
module i2c_mfifo_ctrl
  import i2c_mfifo_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [FLD_W-1:0] hi_thr_o,
  output logic [FLD_W-1:0] lo_thr_o,
  output logic             clr_o
);
  logic ctrl_wr;
  assign ctrl_wr = wr_i && (reg_sel_e'(addr_i) == REG_FCTRL);
  assign clr_o   = ctrl_wr && wdata_i[CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_thr_o <= FLD_W'(DEPTH);
      lo_thr_o <= '0;
    end else if (ctrl_wr) begin
      hi_thr_o <= wdata_i[HI_LSB +: FLD_W];
      lo_thr_o <= wdata_i[0 +: FLD_W];
    end
  end

  // R7
  thr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> ($stable(hi_thr_o) && $stable(lo_thr_o)));
endmodule

// File: rtl/i2c_mfifo.sv
module i2c_mfifo
  import i2c_mfifo_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        tx_pop_i,
  output logic [7:0]  tx_data_o,
  input  logic        rx_push_i,
  input  logic [7:0]  rx_data_i,
  output logic        tx_empty_o,
  output logic        tx_full_o,
  output logic        rx_full_o,
  output logic        rx_hi_o
);
  logic [FLD_W-1:0] hi_thr, lo_thr;
  logic             clr;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic [7:0]       rx_dout;
  logic             rx_empty;
  logic             tx_push, rx_pop;

  assign tx_push = wr_i && (reg_sel_e'(addr_i) == REG_TXDATA);
  assign rx_pop  = rd_i && (reg_sel_e'(addr_i) == REG_RXDATA);

  i2c_mfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .hi_thr_o(hi_thr), .lo_thr_o(lo_thr), .clr_o(clr)
  );

  i2c_mfifo_buf #(.DEPTH(DEPTH), .DW(8)) u_tx (
    .clk_i, .rst_ni, .clr_i(clr),
    .push_i(tx_push), .din_i(wdata_i[7:0]), .pop_i(tx_pop_i),
    .dout_o(tx_data_o), .cnt_o(tx_cnt), .empty_o(tx_empty_o), .full_o(tx_full_o)
  );

  i2c_mfifo_buf #(.DEPTH(DEPTH), .DW(8)) u_rx (
    .clk_i, .rst_ni, .clr_i(clr),
    .push_i(rx_push_i), .din_i(rx_data_i), .pop_i(rx_pop),
    .dout_o(rx_dout), .cnt_o(rx_cnt), .empty_o(rx_empty), .full_o(rx_full_o)
  );

  assign rx_hi_o = ({1'b0, hi_thr} <= 9'(rx_cnt));

  always_comb begin
    rdata_o = '0;
    unique case (reg_sel_e'(addr_i))
      REG_RXDATA: rdata_o[7:0] = rx_dout;
      REG_FCTRL:  rdata_o = {16'h0, hi_thr, lo_thr};
      REG_WCNT:   rdata_o = {16'h0, 8'(tx_cnt), 8'(rx_cnt)};
      default:    rdata_o = '0;
    endcase
  end

  // R8
  clr_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (tx_empty_o && rx_empty));
  // R4
  tx_not_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_empty_o && tx_full_o));
endmodule

// File: tb/test_i2c_mfifo.sv
`timescale 1ns/1ps
module test_i2c_mfifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic tx_pop = 1'b0;
  logic [7:0] tx_data;
  logic rx_push = 1'b0;
  logic [7:0] rx_data = '0;
  logic tx_empty, tx_full, rx_full, rx_hi;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  i2c_mfifo i_i2c_mfifo (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .tx_pop_i(tx_pop), .tx_data_o(tx_data),
    .rx_push_i(rx_push), .rx_data_i(rx_data), .tx_empty_o(tx_empty),
    .tx_full_o(tx_full), .rx_full_o(rx_full), .rx_hi_o(rx_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, input logic pop, output logic [31:0] d);
    @(negedge clk); addr = a; rd = pop; #1 d = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic eng_pop(output logic [7:0] d);
    @(negedge clk); d = tx_data; tx_pop = 1'b1;
    @(posedge clk); #1 tx_pop = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] d);
    @(negedge clk); rx_data = d; rx_push = 1'b1;
    @(posedge clk); #1 rx_push = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 tx_empty", {31'h0, tx_empty}, 32'h1);
    chk("R1 flags", {28'h0, tx_full, rx_full, rx_hi, 1'b0}, 32'h0);
    bus_rd(2'd3, 1'b0, v); chk("R1 count", v, 32'h0);
    bus_rd(2'd2, 1'b0, v); chk("R1 ctrl", v, 32'h0000_8000);
  endtask

  task automatic t_tx_order();
    logic [31:0] v; logic [7:0] b;
    bus_wr(2'd0, 32'h11); bus_wr(2'd0, 32'h22); bus_wr(2'd0, 32'hFFFF_01A5);
    bus_rd(2'd3, 1'b0, v); chk("R6 tx count", v, 32'h0000_0300);
    chk("R10 not empty", {31'h0, tx_empty}, 32'h0);
    eng_pop(b); chk("R2 first", {24'h0, b}, 32'h11);
    eng_pop(b); chk("R2 second", {24'h0, b}, 32'h22);
    eng_pop(b); chk("R2 upper bits dropped", {24'h0, b}, 32'hA5);
    chk("R10 empty", {31'h0, tx_empty}, 32'h1);
  endtask

  task automatic t_rx_order();
    logic [31:0] v;
    eng_push(8'h3C); eng_push(8'hC3);
    bus_rd(2'd3, 1'b0, v); chk("R6 rx count", v, 32'h0000_0002);
    bus_rd(2'd1, 1'b1, v); chk("R3 first", v, 32'h3C);
    bus_rd(2'd1, 1'b1, v); chk("R3 second", v, 32'hC3);
    bus_rd(2'd3, 1'b0, v); chk("R3 drained", v, 32'h0);
  endtask

  task automatic t_empty_pop();
    logic [31:0] v; logic [7:0] b;
    bus_rd(2'd1, 1'b1, v); chk("R5 empty read zero", v, 32'h0);
    eng_pop(b); chk("R5 empty tx head zero", {24'h0, b}, 32'h0);
    bus_rd(2'd3, 1'b0, v); chk("R5 counts stay zero", v, 32'h0);
  endtask

  task automatic t_full();
    logic [31:0] v; logic [7:0] b; int bad;
    for (int i = 0; i < 130; i++) bus_wr(2'd0, i);
    chk("R4 tx_full", {31'h0, tx_full}, 32'h1);
    bus_rd(2'd3, 1'b0, v); chk("R4 tx count 128", v, 32'h0000_8000);
    @(negedge clk); addr = 2'd0; wdata = 32'hEE; wr = 1'b1; tx_pop = 1'b1;
    @(posedge clk); #1 wr = 1'b0; tx_pop = 1'b0;
    bus_rd(2'd3, 1'b0, v); chk("R4 push on full with pop dropped", v, 32'h0000_7F00);
    bad = 0;
    for (int i = 1; i < 128; i++) begin
      eng_pop(b);
      if (b !== 8'(i)) bad++;
    end
    chk("R4 contents kept", bad, 0);
    chk("R10 empty after drain", {31'h0, tx_empty}, 32'h1);
    for (int i = 0; i < 129; i++) eng_push(8'(i + 7));
    chk("R4 rx_full", {31'h0, rx_full}, 32'h1);
    bus_rd(2'd3, 1'b0, v); chk("R4 rx count 128", v, 32'h0000_0080);
    bus_rd(2'd1, 1'b1, v); chk("R4 rx head", v, 32'h07);
    chk("R4 rx not full", {31'h0, rx_full}, 32'h0);
  endtask

  task automatic t_thresh();
    logic [31:0] v;
    bus_wr(2'd2, 32'h0001_0000);
    bus_wr(2'd2, 32'hFFFE_0301);
    bus_rd(2'd2, 1'b0, v); chk("R7 ctrl readback", v, 32'h0000_0301);
    eng_push(8'h01); eng_push(8'h02);
    chk("R9 below", {31'h0, rx_hi}, 32'h0);
    eng_push(8'h03);
    chk("R9 at level", {31'h0, rx_hi}, 32'h1);
    bus_wr(2'd2, 32'h0000_0500);
    chk("R9 raised watermark", {31'h0, rx_hi}, 32'h0);
    bus_wr(2'd2, 32'h0000_0200);
    chk("R9 lowered watermark", {31'h0, rx_hi}, 32'h1);
    bus_rd(2'd1, 1'b1, v);
    chk("R9 still at level", {31'h0, rx_hi}, 32'h1);
    bus_rd(2'd1, 1'b1, v);
    chk("R9 dropped below", {31'h0, rx_hi}, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin bus_wr(2'd0, i); eng_push(8'(i)); end
    @(negedge clk); addr = 2'd2; wdata = 32'h0001_0400; wr = 1'b1;
    rx_push = 1'b1; rx_data = 8'h5A; tx_pop = 1'b1;
    @(posedge clk); #1 wr = 1'b0; rx_push = 1'b0; tx_pop = 1'b0;
    bus_rd(2'd3, 1'b0, v); chk("R8 both cleared over push", v, 32'h0);
    chk("R8 tx_empty", {31'h0, tx_empty}, 32'h1);
    bus_rd(2'd2, 1'b0, v); chk("R7 clear bit reads zero", v, 32'h0000_0400);
    bus_rd(2'd1, 1'b1, v); chk("R8 rx empty read", v, 32'h0);
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_tx_order();
    t_rx_order();
    t_empty_pop();
    t_full();
    t_thresh();
    t_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule